// File: doc/BRIEF.md
# Sub-word Load Alignment Unit

This block sits between a load/store pipeline and a 32-bit data memory and handles the address and data side of a single load. A request carries a base value and one of two offsets. The offset is either a register value or a short immediate field. The request also gives an access size (byte, halfword or word), a signed/unsigned flag and a flag that marks a PC-relative load. The block forms the effective address and reads the whole aligned word that contains it. From that word it picks the wanted byte or halfword lane and widens it to 32 bits.

The unit handles one load at a time. When it accepts a request, it drops `reqReady` and pulses `memReadEn` once with the aligned address. It then waits for the memory to raise `memRdValid`. One cycle after the data arrives, it pulses `resValid` with the extended result and then accepts the next request. The memory array and the register file are outside the block.

Top module: `subword_load_unit`

## Requirements
- R1: `memAddr` is the effective address with bits [1:0] forced to zero. It is presented with the `memReadEn` pulse and held unchanged until the result is delivered.
- R2: For a byte load (`reqSize` = 2'b00), effective-address bits [1:0] pick the lane. Lane k is bits [8k+7:8k] of `memRdData`.
- R3: For a halfword load (`reqSize` = 2'b01), effective-address bit 1 picks the upper half (bits [31:16]) when 1 and the lower half when 0. Address bit 0 has no effect on the result.
- R4: When `reqSigned` = 0, a byte or halfword result is zero-extended to 32 bits.
- R5: When `reqSigned` = 1, a byte result is sign-extended from its bit 7 and a halfword result from its bit 15.
- R6: When `reqUseImm` = 1, the immediate is zero-extended and then scaled before it is added to the base. The scale is 4 for a word (`reqSize` = 2'b10 or 2'b11), 2 for a halfword and 1 for a byte.
- R7: When `reqUseImm` = 0, `reqRegOffset` is added to the base unscaled, with modulo 2^ADDR_W wraparound.
- R8: When `reqPcRel` = 1, the base has bits [1:0] cleared before the offset is added.
- R9: `resValid` is a single-cycle pulse. It appears in the cycle after the clock edge at which `memRdValid` was seen high while a load was waiting.
- R10: `reqReady` is low from the cycle after a request is accepted until the cycle after `resValid`. A `reqValid` asserted while `reqReady` is low starts no read and does not change the pending load.
- R11: `memReadEn` is a single-cycle pulse in the cycle right after acceptance, one per accepted request.
- R12: A word load returns all 32 bits of `memRdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request present |
| reqReady | output | 1 | Unit idle; request accepted when both are high |
| reqBase | input | ADDR_W | Base value |
| reqRegOffset | input | ADDR_W | Register offset, added unscaled |
| reqImm | input | IMM_W | Immediate offset field |
| reqUseImm | input | 1 | 1 selects the scaled immediate, 0 the register offset |
| reqSize | input | 2 | 00 byte, 01 halfword, 10/11 word |
| reqSigned | input | 1 | 1 sign-extends sub-word results |
| reqPcRel | input | 1 | 1 clears base bits [1:0] before the add |
| memReadEn | output | 1 | One-cycle read strobe |
| memAddr | output | ADDR_W | Word-aligned read address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Aligned word read from memory |
| resValid | output | 1 | One-cycle result strobe |
| resData | output | 32 | Extended load result |

## Verification
The bench uses the default parameters, ADDR_W = 32 and IMM_W = 8. With these values the address sum can wrap past the top of the address space, which exercises R7. The largest immediate, 255, scales to offsets of 510 and 1020, so the shift path of R6 is tested at its full width rather than only on small values. Memory latency changes from load to load. Requests are also held high while a load is pending, so the busy window of R10 is exercised both early and late in a load.

// File: rtl/slu_pkg.sv
package slu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES = WORD_W / LANE_W;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned HALVES = 2;
  localparam int unsigned LANE_IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch request, form effective address
    logic issue;    // read strobe cycle
    logic load;     // memory data valid, latch extended result
    logic respond;  // result cycle
  } ctlStrobes_t;
endpackage

// File: rtl/slu_ctrl.sv
module slu_ctrl
  import slu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRdValid,
  output logic        reqReady,
  output ctlStrobes_t ctl
);
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10,
    ST_RESP  = 2'b11
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (reqValid) stateNext = ST_ISSUE;
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT:  if (memRdValid) stateNext = ST_RESP;
      ST_RESP:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady    = (state == ST_IDLE);
  assign ctl.capture = (state == ST_IDLE) && reqValid;
  assign ctl.issue   = (state == ST_ISSUE);
  assign ctl.load    = (state == ST_WAIT) && memRdValid;
  assign ctl.respond = (state == ST_RESP);
endmodule

// File: rtl/slu_datapath.sv
module slu_datapath
  import slu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] reqRegOffset,
  input  logic [IMM_W-1:0]  reqImm,
  input  logic              reqUseImm,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic              reqPcRel,
  input  logic [WORD_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] resData
);
  localparam int unsigned PAD_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] baseEff, immExt, immScaled, offsetSel, eaNext, eaQ;
  logic [1:0]        sizeQ;
  logic              signedQ;
  logic [WORD_W-1:0] resQ, extended;

  // address formation
  always_comb begin
    baseEff = reqBase;
    if (reqPcRel) baseEff[LANE_IDX_W-1:0] = '0;
    immExt = {{PAD_W{1'b0}}, reqImm};
    unique case (reqSize)
      SZ_BYTE: immScaled = immExt;
      SZ_HALF: immScaled = immExt << 1;
      default: immScaled = immExt << 2;
    endcase
    offsetSel = reqUseImm ? immScaled : reqRegOffset;
    eaNext    = baseEff + offsetSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ     <= '0;
      sizeQ   <= SZ_WORD;
      signedQ <= 1'b0;
    end else if (ctl.capture) begin
      eaQ     <= eaNext;
      sizeQ   <= reqSize;
      signedQ <= reqSigned;
    end
  end

  assign memAddr = {eaQ[ADDR_W-1:LANE_IDX_W], {LANE_IDX_W{1'b0}}};

  // lane split
  logic [LANE_W-1:0] lanes  [LANES];
  logic [HALF_W-1:0] halves [HALVES];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign lanes[g] = memRdData[g*LANE_W +: LANE_W];
  end
  for (genvar h = 0; h < HALVES; h++) begin : gHalf
    assign halves[h] = memRdData[h*HALF_W +: HALF_W];
  end

  logic [LANE_W-1:0] byteSel;
  logic [HALF_W-1:0] halfSel;

  always_comb begin
    byteSel = lanes[eaQ[LANE_IDX_W-1:0]];
    halfSel = halves[eaQ[LANE_IDX_W-1]];
    unique case (sizeQ)
      SZ_BYTE: extended = {{(WORD_W-LANE_W){signedQ & byteSel[LANE_W-1]}}, byteSel};
      SZ_HALF: extended = {{(WORD_W-HALF_W){signedQ & halfSel[HALF_W-1]}}, halfSel};
      default: extended = memRdData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         resQ <= '0;
    else if (ctl.load) resQ <= extended;
  end

  assign resData = resQ;
endmodule

// File: rtl/subword_load_unit.sv
module subword_load_unit
  import slu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [ADDR_W-1:0] reqRegOffset,
  input  logic [IMM_W-1:0]  reqImm,
  input  logic              reqUseImm,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic              reqPcRel,
  output logic              memReadEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [31:0]       memRdData,
  output logic              resValid,
  output logic [31:0]       resData
);
  ctlStrobes_t ctl;

  slu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRdValid (memRdValid),
    .reqReady   (reqReady),
    .ctl        (ctl)
  );

  slu_datapath #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .reqBase      (reqBase),
    .reqRegOffset (reqRegOffset),
    .reqImm       (reqImm),
    .reqUseImm    (reqUseImm),
    .reqSize      (reqSize),
    .reqSigned    (reqSigned),
    .reqPcRel     (reqPcRel),
    .memRdData    (memRdData),
    .memAddr      (memAddr),
    .resData      (resData)
  );

  assign memReadEn = ctl.issue;
  assign resValid  = ctl.respond;
endmodule

// File: rtl/subword_load_unit_checker.sv
module subword_load_unit_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              memReadEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdValid,
  input logic              resValid
);
  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && !memReadEn) |-> $stable(memAddr));

  assert_res_after_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(memRdValid));

  assert_res_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  assert_busy_on_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReadEn || resValid) |-> !reqReady);

  assert_read_after_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> memReadEn);

  assert_read_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReadEn |=> !memReadEn);
endmodule

bind subword_load_unit subword_load_unit_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .memReadEn  (memReadEn),
  .memAddr    (memAddr),
  .memRdValid (memRdValid),
  .resValid   (resValid)
);

// File: tb/subword_load_unit_bench.sv
`timescale 1ns/100ps
module subword_load_unit_bench;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned IMM_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqBase = '0, reqRegOffset = '0;
  logic [IMM_W-1:0] reqImm = '0;
  logic reqUseImm = 1'b0, reqSigned = 1'b0, reqPcRel = 1'b0;
  logic [1:0] reqSize = 2'b10;
  logic memReadEn;
  logic [ADDR_W-1:0] memAddr;
  logic memRdValid = 1'b0;
  logic [31:0] memRdData = 32'h0;
  logic resValid;
  logic [31:0] resData;

  int checks = 0;
  int fails = 0;
  int loadsIssued = 0;
  int readsSeen = 0;

  logic [31:0] expAddrQ[$], memWordQ[$], expDataQ[$];
  int latQ[$];
  string memTagQ[$], resTagQ[$];

  always #2.5 clk = ~clk;

  subword_load_unit #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_subword_load_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBase(reqBase), .reqRegOffset(reqRegOffset), .reqImm(reqImm),
    .reqUseImm(reqUseImm), .reqSize(reqSize), .reqSigned(reqSigned),
    .reqPcRel(reqPcRel), .memReadEn(memReadEn), .memAddr(memAddr),
    .memRdValid(memRdValid), .memRdData(memRdData),
    .resValid(resValid), .resData(resData)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // reference model built from the requirements
  function automatic logic [31:0] refEa(input logic [31:0] base, input logic [31:0] regOff,
      input logic [7:0] imm, input bit useImm, input logic [1:0] size, input bit pcRel);
    logic [31:0] b, off;
    b = pcRel ? {base[31:2], 2'b00} : base;
    if (useImm) begin
      off = {24'h0, imm};
      if (size == 2'b01) off = off * 2;
      else if (size != 2'b00) off = off * 4;
    end else off = regOff;
    return b + off;
  endfunction

  function automatic logic [31:0] refData(input logic [31:0] ea, input logic [1:0] size,
      input bit sgn, input logic [31:0] word);
    logic [31:0] sh;
    logic [7:0] b8;
    logic [15:0] h16;
    case (size)
      2'b00: begin
        sh = word >> (8 * ea[1:0]);
        b8 = sh[7:0];
        return sgn ? {{24{b8[7]}}, b8} : {24'h0, b8};
      end
      2'b01: begin
        h16 = ea[1] ? word[31:16] : word[15:0];
        return sgn ? {{16{h16[15]}}, h16} : {16'h0, h16};
      end
      default: return word;
    endcase
  endfunction

  task automatic doLoad(input string tag, input logic [31:0] base, input logic [31:0] regOff,
      input logic [7:0] imm, input bit useImm, input logic [1:0] size, input bit sgn,
      input bit pcRel, input logic [31:0] word, input int lat);
    logic [31:0] ea;
    ea = refEa(base, regOff, imm, useImm, size, pcRel);
    expAddrQ.push_back({ea[31:2], 2'b00});
    memWordQ.push_back(word);
    latQ.push_back(lat);
    memTagQ.push_back(tag);
    expDataQ.push_back(refData(ea, size, sgn, word));
    resTagQ.push_back(tag);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqBase = base; reqRegOffset = regOff; reqImm = imm;
    reqUseImm = useImm; reqSize = size; reqSigned = sgn; reqPcRel = pcRel;
    @(negedge clk);
    reqValid = 1'b0;
    loadsIssued++;
    // R10: busy right after acceptance
    check(reqReady == 1'b0, "R10", "reqReady after accept", {31'h0, reqReady}, 32'h0);
  endtask

  // memory model: checks the aligned address and answers after a latency
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && memReadEn) begin
        readsSeen++;
        if (expAddrQ.size() == 0) begin
          check(1'b0, "R10", "unexpected read strobe", memAddr, 32'h0);
        end else begin
          logic [31:0] ea, w;
          int lat;
          string tg;
          ea = expAddrQ.pop_front(); w = memWordQ.pop_front();
          lat = latQ.pop_front(); tg = memTagQ.pop_front();
          // R1: aligned read address
          check(memAddr == ea, {"R1 ", tg}, "memAddr", memAddr, ea);
          repeat (lat) @(negedge clk);
          memRdValid = 1'b1; memRdData = w;
          @(negedge clk);
          memRdValid = 1'b0; memRdData = 32'hDEAD_BEEF;
        end
      end
    end
  end

  // monitor: pops expected results as they appear
  bit sawData = 1'b0;
  bit prevRes = 1'b0;
  initial begin
    forever begin
      @(posedge clk);
      sawData = memRdValid;
      @(negedge clk);
      if (rstN && resValid) begin
        // R9: result one cycle after data, single pulse
        check(sawData && !prevRes, "R9", "resValid timing", {31'h0, sawData}, 32'h1);
        if (expDataQ.size() == 0) begin
          check(1'b0, "R9", "result with nothing pending", resData, 32'h0);
        end else begin
          logic [31:0] e;
          string tg;
          e = expDataQ.pop_front(); tg = resTagQ.pop_front();
          check(resData == e, tg, "resData", resData, e);
        end
      end
      prevRes = rstN && resValid;
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "WDOG", "run did not finish", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "RST", "reqReady", {31'h0, reqReady}, 32'h1);
    check(resValid == 1'b0, "RST", "resValid", {31'h0, resValid}, 32'h0);
    check(memReadEn == 1'b0, "RST", "memReadEn", {31'h0, memReadEn}, 32'h0);

    // R12 R6: word with immediate scaled by 4
    doLoad("R12_R6_word_imm", 32'h0000_1000, 32'h0, 8'd3, 1'b1, 2'b10, 1'b0, 1'b0, 32'hCAFE_F00D, 1);
    // R3 R4: halfword, odd address, upper half unsigned
    doLoad("R3_R4_half_hi_u", 32'h0000_2001, 32'h0, 8'd1, 1'b1, 2'b01, 1'b0, 1'b0, 32'h8765_4321, 2);
    // R3 R5: same, signed
    doLoad("R3_R5_half_hi_s", 32'h0000_2001, 32'h0, 8'd1, 1'b1, 2'b01, 1'b1, 1'b0, 32'h8765_4321, 3);
    // R3: lower half, bit0 set ignored
    doLoad("R3_half_lo", 32'h0000_2000, 32'h1, 8'd0, 1'b0, 2'b01, 1'b1, 1'b0, 32'h1234_F00F, 1);
    // R2 R7: every byte lane via register offset
    for (int k = 0; k < 4; k++)
      doLoad("R2_R7_byte_lane", 32'h0000_3000, k, 8'd0, 1'b0, 2'b00, 1'b0, 1'b0, 32'hA1B2_C3D4, k + 1);
    // R5: signed byte negative and positive
    doLoad("R5_byte_neg", 32'h0000_3001, 32'h0, 8'd0, 1'b0, 2'b00, 1'b1, 1'b0, 32'h0000_8000, 2);
    doLoad("R5_byte_pos", 32'h0000_3002, 32'h0, 8'd0, 1'b0, 2'b00, 1'b1, 1'b0, 32'h007F_0000, 1);
    // R6: byte immediate unscaled
    doLoad("R6_byte_imm", 32'h0000_4000, 32'h0, 8'd5, 1'b1, 2'b00, 1'b0, 1'b0, 32'h5566_7788, 1);
    // R6: largest immediate, halfword and word scaling
    doLoad("R6_half_imm_max", 32'h0, 32'h0, 8'hFF, 1'b1, 2'b01, 1'b0, 1'b0, 32'hBEEF_0001, 2);
    doLoad("R6_word_imm_max", 32'h0, 32'h0, 8'hFF, 1'b1, 2'b10, 1'b0, 1'b0, 32'h0BAD_CAFE, 1);
    // R8: pc-relative base alignment changes the lane
    doLoad("R8_pcrel_byte", 32'h0000_5003, 32'h1, 8'd0, 1'b0, 2'b00, 1'b0, 1'b1, 32'h4433_2211, 1);
    doLoad("R8_pcrel_word", 32'h0000_5003, 32'h0, 8'd2, 1'b1, 2'b11, 1'b0, 1'b1, 32'h9999_0000, 2);
    // R7: address wraparound
    doLoad("R7_wrap", 32'hFFFF_FFFC, 32'h8, 8'd0, 1'b0, 2'b10, 1'b0, 1'b0, 32'h0102_0304, 1);

    // R10: requests held while busy are ignored
    doLoad("R10_busy_kept", 32'h0000_6000, 32'h2, 8'd0, 1'b0, 2'b01, 1'b0, 1'b0, 32'h7E57_1234, 4);
    reqValid = 1'b1; reqBase = 32'h0000_7777; reqSize = 2'b00; reqRegOffset = 32'h3;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    // R11: single pulse per request, observed through the next load
    doLoad("R11_after_busy", 32'h0000_8000, 32'h0, 8'd1, 1'b1, 2'b10, 1'b0, 1'b0, 32'h1111_2222, 1);

    for (int t = 0; t < 200 && resTagQ.size() != 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(resTagQ.size() == 0, "R9", "results outstanding", resTagQ.size(), 32'h0);
    check(readsSeen == loadsIssued, "R11", "read strobes per request", readsSeen, loadsIssued);
    finishRun();
  end
endmodule